// File: doc/BRIEF.md
# Page Buffer Column Pointer

This block keeps the column pointer for a 528-byte page buffer made of 512 main bytes and 16 spare bytes. It does not hold the buffer RAM and does not move data to or from the array. It tracks three things. The first is which part of the page the next access starts in. The second is the byte index the next data strobe reaches. The third is when a sequential read runs off the end of the page and the next page must be loaded.

An area-select command chooses one of three pointer planes:
- Byte 0x00 selects the lower half, which starts at byte 0.
- Byte 0x01 selects the upper half, which starts at byte 256.
- Byte 0x50 selects the spare area, which starts at byte 512.

A start-column byte then sets the exact start within the plane. Each read or write strobe moves the pointer on by one byte. The spare-enable input decides whether the main planes end at byte 511 or run on through the spare bytes to 527. A read strobe at the last column restarts the pointer at the start of its plane and raises a one-cycle next-page request. Write strobes stop at the last column, and any bytes beyond it are flagged as discarded.

The upper-half selection is used once and then falls back to the lower half. A program or erase completion leaves the spare plane in place and returns the other planes to the lower half.

Top module: `colPtrTop`

## Requirements
- R1: While reset is low, and right after it, colIdx is 0, curPlane is 0, endOfPage is 0 and pageAdvReq is 0.
- R2: A command byte 0x00, 0x01 or 0x50 sets curPlane to 0, 1 or 2 respectively. Any other command byte leaves curPlane and colIdx unchanged.
- R3: An address load sets colIdx to colByte in plane 0 and to 256 + colByte in plane 1. In plane 2 it sets colIdx to 512 + colByte[3:0], and colByte[7:4] are ignored.
- R4: A read or write strobe below the last column advances colIdx by exactly one on that clock edge.
- R5: The last column is 511 in the main planes when spareEn is 1 and 527 when spareEn is 0. In the spare plane it is always 527. endOfPage is high exactly when colIdx is at or past the last column.
- R6: A read strobe at the last column moves colIdx back to 0 (main planes) or 512 (spare plane). It also raises pageAdvReq for exactly one cycle after that edge.
- R7: A write strobe at the last column keeps colIdx there and is kept, so wrKeep is 1. Every later write strobe has wrKeep 0 and leaves colIdx unchanged, until the next address load or read wrap.
- R8: An address load made while curPlane is 1 switches curPlane to 0 on the same edge. The current access still uses the upper-half start and the main-plane wrap rule.
- R9: An opDone pulse moves curPlane from 0 or 1 to 0 and leaves plane 2 unchanged.
- R10: When inputs arrive in the same cycle, cmdValid has the highest priority, then addrValid, then rdStrobe, then wrStrobe. Lower-priority inputs in that cycle have no effect. opDone acts only when neither cmdValid nor addrValid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| cmdValid | input | 1 | Command byte present this cycle |
| cmdByte | input | 8 | Area-select command code |
| addrValid | input | 1 | Start column present this cycle |
| colByte | input | 8 | Start column within the selected plane |
| spareEn | input | 1 | 1 excludes spare bytes from the main planes |
| rdStrobe | input | 1 | One byte read from the buffer |
| wrStrobe | input | 1 | One byte written to the buffer |
| opDone | input | 1 | Program or erase has completed |
| colIdx | output | 10 | Current buffer byte index |
| endOfPage | output | 1 | Pointer is at the last column |
| pageAdvReq | output | 1 | One-cycle request to load the next page |
| curPlane | output | 2 | Plane for the next load: 0 lower, 1 upper, 2 spare |
| wrKeep | output | 1 | The write strobe this cycle lands in the buffer |

## Verification
A corrupted plane register shows up on curPlane at the next sample after the edge. A wrong start-offset base also shows up one cycle after the address load, as a colIdx off by 256 or 512. A stale last-column decision appears on endOfPage right away. A wrap to the wrong start, or a missing next-page pulse, shows up in the cycle after the final read strobe. The one-shot upper-half selection, the plane kept across program completion, and the saturating write pointer are each checked in the cycle right after the event that should change them.

// File: rtl/colPtrPkg.sv
package colPtrPkg;

  // Plane codes as seen on curPlane
  typedef enum logic [1:0] {
    PLANE_LOW   = 2'd0,
    PLANE_HIGH  = 2'd1,
    PLANE_SPARE = 2'd2
  } plane_e;

  localparam logic [7:0] CMD_LOW   = 8'h00;
  localparam logic [7:0] CMD_HIGH  = 8'h01;
  localparam logic [7:0] CMD_SPARE = 8'h50;

  // Strobes from control to the column datapath
  typedef struct packed {
    logic load;      // take loadCol
    logic step;      // advance by one
    logic wrap;      // restart at plane start
    logic markFull;  // last column written
    logic spareMode; // current access lives in the spare plane
  } colOps_t;

endpackage

// File: rtl/colPtrCtrl.sv
module colPtrCtrl
  import colPtrPkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  localparam int COL_W  = $clog2(MAIN_BYTES + SPARE_BYTES),
  localparam int COLB_W = $clog2(MAIN_BYTES / 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              addrValid,
  input  logic [COLB_W-1:0] colByte,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              opDone,
  input  logic              atLast,
  input  logic              isFull,
  output colOps_t           ops,
  output logic [COL_W-1:0]  loadCol,
  output plane_e            planeNow,
  output logic              pageAdvReq,
  output logic              wrKeep
);

  localparam int SP_W = $clog2(SPARE_BYTES);
  localparam logic [COL_W-1:0] HALF_BASE  = COL_W'(MAIN_BYTES / 2);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_BYTES);

  plane_e planeSel;
  plane_e activePlane;
  plane_e cmdPlane;
  logic   cmdHit;
  logic   addrEff, rdEff, wrEff, doneEff;

  // command decode
  always_comb begin
    cmdHit   = 1'b1;
    cmdPlane = PLANE_LOW;
    case (cmdByte)
      CMD_LOW:   cmdPlane = PLANE_LOW;
      CMD_HIGH:  cmdPlane = PLANE_HIGH;
      CMD_SPARE: cmdPlane = PLANE_SPARE;
      default:   cmdHit   = 1'b0;
    endcase
  end

  // fixed priority: command, address, read, write
  assign addrEff = addrValid && !cmdValid;
  assign rdEff   = rdStrobe && !cmdValid && !addrValid;
  assign wrEff   = wrStrobe && !cmdValid && !addrValid && !rdStrobe;
  assign doneEff = opDone && !cmdValid && !addrValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      planeSel <= PLANE_LOW;
    end else if (cmdValid) begin
      if (cmdHit) planeSel <= cmdPlane;
    end else if (addrEff) begin
      if (planeSel == PLANE_HIGH) planeSel <= PLANE_LOW;
    end else if (doneEff) begin
      if (planeSel != PLANE_SPARE) planeSel <= PLANE_LOW;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        activePlane <= PLANE_LOW;
    else if (addrEff) activePlane <= planeSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pageAdvReq <= 1'b0;
    else       pageAdvReq <= rdEff && atLast;
  end

  // start column for the plane in force at load time
  always_comb begin
    case (planeSel)
      PLANE_SPARE: loadCol = SPARE_BASE + COL_W'(colByte[SP_W-1:0]);
      PLANE_HIGH:  loadCol = HALF_BASE + COL_W'(colByte);
      default:     loadCol = COL_W'(colByte);
    endcase
  end

  always_comb begin
    ops.load      = addrEff;
    ops.step      = (rdEff || wrEff) && !atLast;
    ops.wrap      = rdEff && atLast;
    ops.markFull  = wrEff && atLast && !isFull;
    ops.spareMode = (activePlane == PLANE_SPARE);
  end

  assign wrKeep   = wrEff && !isFull;
  assign planeNow = planeSel;

endmodule

// File: rtl/colPtrPath.sv
module colPtrPath
  import colPtrPkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  localparam int COL_W = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  colOps_t          ops,
  input  logic [COL_W-1:0] loadCol,
  input  logic             spareEn,
  output logic [COL_W-1:0] colIdx,
  output logic             atLast,
  output logic             isFull
);

  localparam logic [COL_W-1:0] LAST_MAIN  = COL_W'(MAIN_BYTES - 1);
  localparam logic [COL_W-1:0] LAST_FULL  = COL_W'(MAIN_BYTES + SPARE_BYTES - 1);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_BYTES);

  logic [COL_W-1:0] lastCol;
  logic [COL_W-1:0] wrapCol;

  assign lastCol = (ops.spareMode || !spareEn) ? LAST_FULL : LAST_MAIN;
  assign wrapCol = ops.spareMode ? SPARE_BASE : '0;
  // at-or-past keeps the pointer bounded if spareEn rises mid-page
  assign atLast  = (colIdx >= lastCol);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colIdx <= '0;
      isFull <= 1'b0;
    end else if (ops.load) begin
      colIdx <= loadCol;
      isFull <= 1'b0;
    end else if (ops.wrap) begin
      colIdx <= wrapCol;
      isFull <= 1'b0;
    end else if (ops.step) begin
      colIdx <= colIdx + COL_W'(1);
    end else if (ops.markFull) begin
      isFull <= 1'b1;
    end
  end

endmodule

// File: rtl/colPtrTop.sv
module colPtrTop
  import colPtrPkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  localparam int COL_W  = $clog2(MAIN_BYTES + SPARE_BYTES),
  localparam int COLB_W = $clog2(MAIN_BYTES / 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              addrValid,
  input  logic [COLB_W-1:0] colByte,
  input  logic              spareEn,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              opDone,
  output logic [COL_W-1:0]  colIdx,
  output logic              endOfPage,
  output logic              pageAdvReq,
  output logic [1:0]        curPlane,
  output logic              wrKeep
);

  colOps_t          ops;
  logic [COL_W-1:0] loadCol;
  logic             atLast;
  logic             isFull;
  plane_e           planeNow;

  colPtrCtrl #(.MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdByte(cmdByte),
    .addrValid(addrValid), .colByte(colByte),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .opDone(opDone),
    .atLast(atLast), .isFull(isFull),
    .ops(ops), .loadCol(loadCol), .planeNow(planeNow),
    .pageAdvReq(pageAdvReq), .wrKeep(wrKeep)
  );

  colPtrPath #(.MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES)) path_i (
    .clk(clk), .rstN(rstN),
    .ops(ops), .loadCol(loadCol), .spareEn(spareEn),
    .colIdx(colIdx), .atLast(atLast), .isFull(isFull)
  );

  assign endOfPage = atLast;
  assign curPlane  = planeNow;

endmodule

// File: rtl/colPtrChk.sv
module colPtrChk #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  localparam int COL_W = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             addrValid,
  input logic             rdStrobe,
  input logic             wrStrobe,
  input logic             opDone,
  input logic [COL_W-1:0] colIdx,
  input logic             endOfPage,
  input logic             pageAdvReq,
  input logic [1:0]       curPlane,
  input logic             wrKeep
);

  localparam logic [COL_W-1:0] TOP_COL    = COL_W'(MAIN_BYTES + SPARE_BYTES - 1);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_BYTES);

  // R5
  col_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    colIdx <= TOP_COL);

  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !cmdValid && !addrValid && !endOfPage |=> colIdx == $past(colIdx) + COL_W'(1));

  // R6
  rd_wrap_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !cmdValid && !addrValid && endOfPage |=> pageAdvReq);

  // R6
  adv_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageAdvReq |=> !pageAdvReq);

  // R3
  spare_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !cmdValid && curPlane == 2'd2 |=> colIdx >= SPARE_BASE && colIdx <= TOP_COL);

  // R8
  high_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !cmdValid && curPlane == 2'd1 |=> curPlane == 2'd0);

  // R9
  spare_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    opDone && !cmdValid && !addrValid && curPlane == 2'd2 |=> curPlane == 2'd2);

  // R7
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && !wrKeep && !cmdValid && !addrValid && !rdStrobe |=> $stable(colIdx));

endmodule

bind colPtrTop colPtrChk #(.MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES)) chk_i (.*);

// File: tb/colPtrTop_tb_top.sv
module colPtrTop_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdValid, addrValid, spareEn, rdStrobe, wrStrobe, opDone;
  logic [7:0] cmdByte, colByte;
  logic [9:0] colIdx;
  logic       endOfPage, pageAdvReq, wrKeep;
  logic [1:0] curPlane;

  int vecCount  = 0;
  int missCount = 0;

  always #4 clk = ~clk; // 125 MHz

  colPtrTop dut_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdByte(cmdByte),
    .addrValid(addrValid), .colByte(colByte),
    .spareEn(spareEn), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .opDone(opDone),
    .colIdx(colIdx), .endOfPage(endOfPage), .pageAdvReq(pageAdvReq),
    .curPlane(curPlane), .wrKeep(wrKeep)
  );

  // {req[4], op[3], data[8], se, col[10], eop, adv, plane[2], keep}
  // op: 0 idle, 1 command, 2 address, 3 read, 4 write, 5 done
  localparam int NV = 30;
  localparam logic [30:0] VEC [NV] = '{
    {4'd2, 3'd1, 8'h00, 1'b0, 10'd0,   1'b0, 1'b0, 2'd0, 1'b0}, // R2 lower
    {4'd3, 3'd2, 8'h05, 1'b0, 10'd5,   1'b0, 1'b0, 2'd0, 1'b0}, // R3
    {4'd4, 3'd3, 8'h00, 1'b0, 10'd6,   1'b0, 1'b0, 2'd0, 1'b0}, // R4 read
    {4'd4, 3'd4, 8'h00, 1'b0, 10'd7,   1'b0, 1'b0, 2'd0, 1'b1}, // R4 write
    {4'd2, 3'd1, 8'h01, 1'b0, 10'd7,   1'b0, 1'b0, 2'd1, 1'b0}, // R2 upper
    {4'd8, 3'd2, 8'hFE, 1'b0, 10'd510, 1'b0, 1'b0, 2'd0, 1'b0}, // R8 reverts
    {4'd5, 3'd3, 8'h00, 1'b1, 10'd511, 1'b1, 1'b0, 2'd0, 1'b0}, // R5 last 511
    {4'd6, 3'd3, 8'h00, 1'b1, 10'd0,   1'b0, 1'b1, 2'd0, 1'b0}, // R6 wrap
    {4'd6, 3'd0, 8'h00, 1'b1, 10'd0,   1'b0, 1'b0, 2'd0, 1'b0}, // R6 pulse ends
    {4'd2, 3'd1, 8'h50, 1'b1, 10'd0,   1'b0, 1'b0, 2'd2, 1'b0}, // R2 spare
    {4'd3, 3'd2, 8'hFC, 1'b1, 10'd524, 1'b0, 1'b0, 2'd2, 1'b0}, // R3 upper nibble ignored
    {4'd5, 3'd3, 8'h00, 1'b1, 10'd525, 1'b0, 1'b0, 2'd2, 1'b0}, // R5
    {4'd5, 3'd3, 8'h00, 1'b1, 10'd526, 1'b0, 1'b0, 2'd2, 1'b0}, // R5
    {4'd5, 3'd3, 8'h00, 1'b1, 10'd527, 1'b1, 1'b0, 2'd2, 1'b0}, // R5 spare last
    {4'd6, 3'd3, 8'h00, 1'b1, 10'd512, 1'b0, 1'b1, 2'd2, 1'b0}, // R6 spare wrap
    {4'd9, 3'd5, 8'h00, 1'b1, 10'd512, 1'b0, 1'b0, 2'd2, 1'b0}, // R9 spare kept
    {4'd2, 3'd1, 8'h00, 1'b0, 10'd512, 1'b0, 1'b0, 2'd0, 1'b0}, // R2
    {4'd3, 3'd2, 8'hFF, 1'b0, 10'd255, 1'b0, 1'b0, 2'd0, 1'b0}, // R3
    {4'd4, 3'd4, 8'h00, 1'b0, 10'd256, 1'b0, 1'b0, 2'd0, 1'b1}, // R4
    {4'd2, 3'd1, 8'h01, 1'b0, 10'd256, 1'b0, 1'b0, 2'd1, 1'b0}, // R2
    {4'd8, 3'd2, 8'hFF, 1'b1, 10'd511, 1'b1, 1'b0, 2'd0, 1'b0}, // R8
    {4'd7, 3'd4, 8'h00, 1'b1, 10'd511, 1'b1, 1'b0, 2'd0, 1'b1}, // R7 last byte kept
    {4'd7, 3'd4, 8'h00, 1'b1, 10'd511, 1'b1, 1'b0, 2'd0, 1'b0}, // R7 extra dropped
    {4'd6, 3'd3, 8'h00, 1'b1, 10'd0,   1'b0, 1'b1, 2'd0, 1'b0}, // R6 upper-half access wraps to 0
    {4'd2, 3'd1, 8'h01, 1'b1, 10'd0,   1'b0, 1'b0, 2'd1, 1'b0}, // R2
    {4'd2, 3'd1, 8'hA5, 1'b1, 10'd0,   1'b0, 1'b0, 2'd1, 1'b0}, // R2 unknown code
    {4'd9, 3'd5, 8'h00, 1'b1, 10'd0,   1'b0, 1'b0, 2'd0, 1'b0}, // R9 upper to lower
    {4'd2, 3'd1, 8'h50, 1'b1, 10'd0,   1'b0, 1'b0, 2'd2, 1'b0}, // R2
    {4'd2, 3'd1, 8'h7F, 1'b1, 10'd0,   1'b0, 1'b0, 2'd2, 1'b0}, // R2 unknown code
    {4'd9, 3'd5, 8'h00, 1'b1, 10'd0,   1'b0, 1'b0, 2'd2, 1'b0}  // R9
  };

  task automatic idleInputs();
    cmdValid = 1'b0; addrValid = 1'b0; rdStrobe = 1'b0; wrStrobe = 1'b0; opDone = 1'b0;
    cmdByte = 8'h00; colByte = 8'h00;
  endtask

  // called at a falling edge; returns wrKeep seen before the rising edge
  task automatic runOp(input logic [2:0] op, input logic [7:0] data, input logic se,
                       output logic keepSeen);
    spareEn   = se;
    cmdValid  = (op == 3'd1);
    addrValid = (op == 3'd2);
    rdStrobe  = (op == 3'd3);
    wrStrobe  = (op == 3'd4);
    opDone    = (op == 3'd5);
    cmdByte   = data;
    colByte   = data;
    #1 keepSeen = wrKeep;
    @(posedge clk);
    @(negedge clk);
    idleInputs();
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    missCount++;
    $display("watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    logic k;
    idleInputs();
    spareEn = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", {22'd0, colIdx, endOfPage, pageAdvReq, curPlane}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {22'd0, colIdx, endOfPage, pageAdvReq, curPlane}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      runOp(VEC[i][26:24], VEC[i][23:16], VEC[i][15], k);
      check($sformatf("R%0d", VEC[i][30:27]),
            {17'd0, colIdx, endOfPage, pageAdvReq, curPlane, k},
            {17'd0, VEC[i][14:0]});
    end

    // R5 main plane with spare included: last column is 527
    runOp(3'd1, 8'h00, 1'b0, k);
    runOp(3'd2, 8'hFF, 1'b0, k);
    for (int n = 0; n < 256; n++) runOp(3'd3, 8'h00, 1'b0, k);
    check("R5", {21'd0, colIdx, endOfPage}, {21'd0, 10'd511, 1'b0});
    for (int n = 0; n < 16; n++) runOp(3'd3, 8'h00, 1'b0, k);
    check("R5", {21'd0, colIdx, endOfPage}, {21'd0, 10'd527, 1'b1});
    runOp(3'd3, 8'h00, 1'b0, k);
    // R6 main plane wrap to 0
    check("R6", {21'd0, colIdx, pageAdvReq}, {21'd0, 10'd0, 1'b1});

    // R10 address beats read in the same cycle
    runOp(3'd2, 8'h10, 1'b0, k);
    spareEn = 1'b0; addrValid = 1'b1; colByte = 8'h20; rdStrobe = 1'b1;
    @(posedge clk); @(negedge clk); idleInputs();
    check("R10", {22'd0, colIdx}, {22'd0, 10'd32});
    // R10 command beats address in the same cycle
    cmdValid = 1'b1; cmdByte = 8'h50; addrValid = 1'b1; colByte = 8'h03;
    @(posedge clk); @(negedge clk); idleInputs();
    check("R10", {20'd0, colIdx, curPlane}, {20'd0, 10'd32, 2'd2});
    // R10 read beats write: one step only, write not kept
    spareEn = 1'b0; rdStrobe = 1'b1; wrStrobe = 1'b1;
    #1 k = wrKeep;
    @(posedge clk); @(negedge clk); idleInputs();
    check("R10", {21'd0, colIdx, k}, {21'd0, 10'd33, 1'b0});

    // R1 reset mid-run returns to plane 0, column 0
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {22'd0, colIdx, endOfPage, pageAdvReq, curPlane}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule